// File: doc/BRIEF.md
# Refresh Interval Timer

This block is an 8-bit timer. Depending on its mode bits, it either paces RAM refresh or works as a general interval timer. A free-running divider of the system clock supplies a count tick at one of seven rates. Each tick advances an up-counter, which is compared with a programmable constant. When the counter reaches the constant, the next tick returns the counter to zero and produces a compare event.

The mode bits select what a compare event does:

- **Refresh mode** (either RAM mode bit set): the event posts a refresh request toward an external refresh sequencer. The request stays pending until the bus is granted. The sequencer then reports the running cycle through a done input.
- **Interval-timer mode**: the event sets a sticky compare flag, which can raise an interrupt.

Software reaches the control/status register, the counter and the constant through a small synchronous register port with a combinational read path.

Top module: `rfsh_itimer`

## Requirements
- R1: After reset the control register reads 0x00, the counter reads 0x00 and the constant reads 0xFF, with `irq`, `rfsh_req` and `rfsh_active` low.
- R2: The register port decodes `addr` 0 as control/status, 1 as counter and 2 as constant. Control bit positions are: bit 7 compare flag, bit 6 interrupt enable, bits 5:3 clock select, bit 1 DRAM mode, bit 0 pseudo-static RAM mode. Bit 2 reads 0.
- R3: Clock select codes 1 to 7 give one count tick every 2, 8, 32, 128, 512, 2048 or 4096 system clocks. Compare events then repeat every (constant+1)×divisor cycles.
- R4: With clock select 0 the counter holds its value and no compare event occurs.
- R5: On a tick while the counter equals the constant, the counter becomes 0 and the compare flag is set.
- R6: A counter write in the same cycle as a tick loads the written value; no increment or compare occurs that cycle.
- R7: The compare flag clears only when a control write with bit 7 = 0 follows a control read that returned bit 7 = 1. Writing 1 to bit 7 never sets it. A compare event in the clearing cycle wins.
- R8: `irq` equals compare flag AND interrupt enable.
- R9: While either RAM mode bit is set, the interrupt enable reads 0 and cannot be written to 1. Setting a mode bit clears it.
- R10: A compare event in refresh mode raises `rfsh_req`, which stays high until `bus_grant` is sampled high while no refresh cycle runs.
- R11: An accepted grant drops `rfsh_req` and raises `rfsh_active` until `rfsh_done`. While `rfsh_active` is high, grants are ignored, and any number of compare events leave a single pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| bus_grant | input | 1 | Bus granted to the refresh sequencer |
| rfsh_done | input | 1 | Refresh cycle finished |
| rfsh_req | output | 1 | Refresh request pending |
| rfsh_active | output | 1 | Refresh cycle in progress |
| irq | output | 1 | Compare-match interrupt |

## Verification
The hardest state to reach is a second compare event arriving while a granted refresh cycle is still running. It must leave exactly one request pending and ignore further grants. The stimulus builds this state step by step:

1. Hold `rfsh_done` low after a grant, so the cycle stays active.
2. Let the counter run through several more compare periods.
3. Pulse `bus_grant` while the cycle is active.
4. Stop the clock select before ending the cycle, so no new event can coincide with the final grant.

Exact clear and increment cycles are exposed by measuring request spacing with grant and done held high.

// File: rtl/rit_pkg.sv
// Package rit_pkg
// Shared register addresses, control-register bit positions and the
// prescale tap function for the refresh interval timer.
// Assumes an 8-bit register port.
package rit_pkg;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_CONST = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    localparam int CB_FLAG  = 7;
    localparam int CB_IE    = 6;
    localparam int CB_CKS   = 3;
    localparam int CB_RSVD  = 2;
    localparam int CB_DRAM  = 1;
    localparam int CB_PSRAM = 0;
    localparam int SEL_W    = 3;

    // log2 of the divisor for a clock-select code (code 0 unused)
    function automatic int tap_log2(input int code);
        if (code >= 7) return 12;
        return 2 * code - 1;
    endfunction

endpackage

// File: rtl/rit_prescaler.sv
// Module rit_prescaler
// Free-running divider of the system clock that emits a one-cycle tick
// every 2^k cycles, with k chosen by the clock-select code. Code 0
// emits no tick. The divider runs continuously, so a changed selection
// takes effect at the next tap boundary.
module rit_prescaler
    import rit_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int NCODE = 1 << SW;
    localparam int DIV_W = tap_log2(NCODE - 1);

    logic [DIV_W-1:0] div_q;
    logic [NCODE-1:0] tap_hit;

    // Advance the divider every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tap_hit[0] = 1'b0;

    for (genvar gi = 1; gi < NCODE; gi++) begin : g_tap
        localparam int K = tap_log2(gi);
        // Tap gi fires when its low K divider bits are all ones
        assign tap_hit[gi] = &div_q[K-1:0];
    end

    // Select the tap for the current code
    always_comb tick = tap_hit[sel];

endmodule

// File: rtl/rit_counter.sv
// Module rit_counter
// Up-counter with compare. On a tick it increments, or clears to zero
// and pulses match when it already equals the compare value. A write
// loads wdata and takes priority over the tick, suppressing match.
module rit_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] count,
    output logic         match
);
    logic hit;

    // Compare event only on an unwritten tick
    always_comb begin
        hit   = (count == cmp);
        match = tick && !wr && hit;
    end

    // Load, clear on compare, or increment
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (wr)     count <= wdata;
        else if (match)  count <= '0;
        else if (tick)   count <= count + 1'b1;
    end

endmodule

// File: rtl/rit_refresh_arb.sv
// Module rit_refresh_arb
// Holds one pending refresh request and tracks the running refresh
// cycle. A grant is accepted only while no cycle runs. Events arriving
// while a request is pending merge into it.
module rit_refresh_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic event_in,
    input  logic rf_mode,
    input  logic grant,
    input  logic done,
    output logic req,
    output logic active
);
    logic accept;

    // Grant counts only for a pending request with the bus idle
    always_comb accept = req && grant && !active;

    // Pending request: set by an event, dropped on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= (req && !accept) || (event_in && rf_mode);
    end

    // Running cycle: starts on acceptance, ends on done
    always_ff @(posedge clk) begin
        if (!rst_n)      active <= 1'b0;
        else if (accept) active <= 1'b1;
        else if (done)   active <= 1'b0;
    end

endmodule

// File: rtl/rfsh_itimer.sv
// Module rfsh_itimer
// Refresh and interval timer top. Holds the control/status and constant
// registers, the flag-clear protocol and the interrupt masking. Wires
// the prescaler, counter and refresh arbiter together.
// Assumes synchronous active-low reset and single-cycle register strobes.
module rfsh_itimer
    import rit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              bus_grant,
    input  logic              rfsh_done,
    output logic              rfsh_req,
    output logic              rfsh_active,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CONST_RST = '1;

    logic [SEL_W-1:0]  cks;
    logic              cmie, cmf, arm, dram_en, psram_en;
    logic [DATA_W-1:0] cmp_q, count;
    logic              tick, match, rf_mode;
    logic              wr_ctrl, wr_cnt, wr_cmp, rd_ctrl;
    logic              new_dram, new_psram;

    // Decode register strobes
    always_comb begin
        wr_ctrl   = wr_en && (addr == RA_CTRL);
        wr_cnt    = wr_en && (addr == RA_COUNT);
        wr_cmp    = wr_en && (addr == RA_CONST);
        rd_ctrl   = rd_en && (addr == RA_CTRL);
        new_dram  = wr_ctrl ? wdata[CB_DRAM]  : dram_en;
        new_psram = wr_ctrl ? wdata[CB_PSRAM] : psram_en;
        rf_mode   = dram_en || psram_en;
    end

    // Mode bits and clock select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cks      <= '0;
            dram_en  <= 1'b0;
            psram_en <= 1'b0;
        end else if (wr_ctrl) begin
            cks      <= wdata[CB_CKS +: SEL_W];
            dram_en  <= wdata[CB_DRAM];
            psram_en <= wdata[CB_PSRAM];
        end
    end

    // Interrupt enable, forced off while any RAM mode is set
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmie <= 1'b0;
        else
            cmie <= (wr_ctrl ? wdata[CB_IE] : cmie) && !(new_dram || new_psram);
    end

    // Compare constant register
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= CONST_RST;
        else if (wr_cmp) cmp_q <= wdata;
    end

    // Flag-clear arming: set by reading the flag as 1, dropped by any control write
    always_ff @(posedge clk) begin
        if (!rst_n)                arm <= 1'b0;
        else if (wr_ctrl)          arm <= 1'b0;
        else if (rd_ctrl && cmf)   arm <= 1'b1;
    end

    // Compare flag: a compare event sets it, an armed write of 0 clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                                    cmf <= 1'b0;
        else if (match)                                cmf <= 1'b1;
        else if (wr_ctrl && arm && !wdata[CB_FLAG])    cmf <= 1'b0;
    end

    // Combinational read mux
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_CTRL: begin
                rdata[CB_FLAG]            = cmf;
                rdata[CB_IE]              = cmie;
                rdata[CB_CKS +: SEL_W]    = cks;
                rdata[CB_RSVD]            = 1'b0;
                rdata[CB_DRAM]            = dram_en;
                rdata[CB_PSRAM]           = psram_en;
            end
            RA_COUNT: rdata = count;
            RA_CONST: rdata = cmp_q;
            default:  rdata = '0;
        endcase
    end

    // Interrupt output
    always_comb irq = cmf && cmie;

    rit_prescaler #(.SW(SEL_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (cks),
        .tick (tick)
    );

    rit_counter #(.W(DATA_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .wr   (wr_cnt),
        .wdata(wdata),
        .cmp  (cmp_q),
        .count(count),
        .match(match)
    );

    rit_refresh_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_in(match),
        .rf_mode (rf_mode),
        .grant   (bus_grant),
        .done    (rfsh_done),
        .req     (rfsh_req),
        .active  (rfsh_active)
    );

endmodule

// File: rtl/rit_checker.sv
// Module rit_checker
// Temporal properties of the refresh interval timer, attached to every
// rfsh_itimer instance by the bind below.
module rit_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [2:0]        cks,
    input logic [DATA_W-1:0] count,
    input logic              match,
    input logic              cmf,
    input logic              dram_en,
    input logic              psram_en,
    input logic              irq,
    input logic              bus_grant,
    input logic              rfsh_req,
    input logic              rfsh_active
);
    logic cnt_wr;
    always_comb cnt_wr = wr_en && (addr == 2'd1);

    AST_CNT_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wdata)));                              // R6
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cks == 3'd0 && !cnt_wr) |=> $stable(count));                     // R4
    AST_HALT_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cks == 3'd0) |-> !match);                                        // R4
    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (count == '0 && cmf));                                  // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cmf);                                                     // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_en || psram_en) |-> !irq);                                  // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req && !(bus_grant && !rfsh_active)) |=> rfsh_req);         // R10
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_active) |-> $past(rfsh_req && bus_grant));             // R11

endmodule

bind rfsh_itimer rit_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .cks        (cks),
    .count      (count),
    .match      (match),
    .cmf        (cmf),
    .dram_en    (dram_en),
    .psram_en   (psram_en),
    .irq        (irq),
    .bus_grant  (bus_grant),
    .rfsh_req   (rfsh_req),
    .rfsh_active(rfsh_active)
);

// File: tb/rfsh_itimer_tb.sv
// Bench for rfsh_itimer: a vector table of prescale/constant/period
// entries walked by one loop, then directed tests.
module rfsh_itimer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd3;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       bus_grant = 1'b0, rfsh_done = 1'b0;
    logic       rfsh_req, rfsh_active, irq;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    rfsh_itimer u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .bus_grant(bus_grant),
        .rfsh_done(rfsh_done), .rfsh_req(rfsh_req),
        .rfsh_active(rfsh_active), .irq(irq)
    );

    // {clock select, constant, expected event period in cycles}
    localparam logic [26:0] TBL [8] = '{
        {3'd1, 8'd3, 16'd8},    {3'd2, 8'd1, 16'd16},
        {3'd3, 8'd0, 16'd32},   {3'd4, 8'd1, 16'd256},
        {3'd5, 8'd0, 16'd512},  {3'd6, 8'd0, 16'd2048},
        {3'd7, 8'd0, 16'd4096}, {3'd1, 8'd1, 16'd4}
    };

    function automatic logic [7:0] ctl(input bit f, input bit ie,
                                       input logic [2:0] ck, input bit dr, input bit ps);
        return {f, ie, ck, 1'b0, dr, ps};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_rise(output int cyc);
        logic prev;
        prev = rfsh_req; cyc = 0;
        while (cyc < 10000) begin
            @(negedge clk); cyc++;
            if (rfsh_req && !prev) break;
            prev = rfsh_req;
        end
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic pulse_grant();
        @(negedge clk); bus_grant = 1'b1;
        @(negedge clk); bus_grant = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R2 address map
        reg_rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        reg_rd(2'd1, d); chk("R1 count", d, 8'h00);
        reg_rd(2'd2, d); chk("R1 const R2", d, 8'hFF);
        chk("R1 irq", irq, 0); chk("R1 req", rfsh_req, 0); chk("R1 active", rfsh_active, 0);

        // R3 prescale taps, walked through the table
        bus_grant = 1'b1; rfsh_done = 1'b1;
        for (int i = 0; i < 8; i++) begin
            reg_wr(2'd2, TBL[i][23:16]);
            reg_wr(2'd1, 8'h00);
            reg_wr(2'd0, ctl(0, 0, TBL[i][26:24], 1, 0));
            wait_rise(cyc); wait_rise(cyc); wait_rise(cyc);
            chk($sformatf("R3 period entry %0d", i), cyc, int'(TBL[i][15:0]));
        end
        reg_wr(2'd0, ctl(0, 0, 3'd0, 0, 0));
        repeat (4) @(negedge clk);
        bus_grant = 1'b0; rfsh_done = 1'b0;

        // R2 readback of control fields
        reg_wr(2'd0, ctl(0, 0, 3'd5, 0, 1));
        reg_rd(2'd0, d); chk("R2 ctrl fields", d & 8'h7F, 8'h29);
        reg_wr(2'd0, ctl(0, 0, 3'd0, 0, 0));
        repeat (3) @(negedge clk);
        chk("R10 no new req after mode off", rfsh_req, 0);

        // R4 halt with select 0
        reg_wr(2'd1, 8'h05);
        repeat (60) @(negedge clk);
        reg_rd(2'd1, d); chk("R4 halt", d, 8'h05);

        // R6 write beats tick: two consecutive writes cover a tick edge
        reg_wr(2'd2, 8'hFF);
        reg_wr(2'd0, ctl(0, 0, 3'd1, 0, 0));
        @(negedge clk); addr = 2'd1; wdata = 8'h40; wr_en = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b0; #1 chk("R6 write priority", rdata, 8'h40);

        // R5 compare clears counter and sets flag, R8 irq
        reg_wr(2'd2, 8'd3);
        reg_wr(2'd1, 8'd0);
        reg_wr(2'd0, ctl(0, 1, 3'd1, 0, 0));
        wait_irq();
        addr = 2'd1; #1 chk("R5 count cleared on match", rdata, 8'h00);
        chk("R8 irq on flag", irq, 1);

        // R7 unarmed write of 0 keeps flag; also stops counting
        reg_wr(2'd0, ctl(0, 1, 3'd0, 0, 0));
        chk("R7 unarmed clear ignored", irq, 1);
        // R8 enable off masks irq, flag still set
        reg_wr(2'd0, ctl(0, 0, 3'd0, 0, 0));
        chk("R8 irq masked", irq, 0);
        reg_rd(2'd0, d); chk("R8 flag kept", d[7], 1);
        reg_wr(2'd0, ctl(1, 1, 3'd0, 0, 0));
        chk("R7 write 1 no clear", irq, 1);
        reg_rd(2'd0, d);
        reg_wr(2'd0, ctl(0, 1, 3'd0, 0, 0));
        chk("R7 armed clear", irq, 0);
        reg_rd(2'd0, d); chk("R7 flag zero", d[7], 0);

        // R9 enable forced off in RAM modes
        reg_wr(2'd0, ctl(0, 1, 3'd0, 1, 0));
        reg_rd(2'd0, d); chk("R9 dram forces ie", d, 8'h02);
        reg_wr(2'd0, ctl(0, 1, 3'd0, 0, 0));
        reg_wr(2'd0, ctl(0, 0, 3'd0, 0, 1));
        reg_rd(2'd0, d); chk("R9 psram clears ie", d, 8'h01);

        // R10 request held until grant
        reg_wr(2'd2, 8'd50);
        reg_wr(2'd1, 8'd0);
        reg_wr(2'd0, ctl(0, 0, 3'd1, 1, 0));
        wait_rise(cyc);
        repeat (40) @(negedge clk);
        chk("R10 req held", rfsh_req, 1);
        chk("R10 not active", rfsh_active, 0);
        pulse_grant();
        chk("R11 req dropped", rfsh_req, 0);
        chk("R11 active", rfsh_active, 1);

        // R11 event during active cycle: one pending, grants ignored
        wait_rise(cyc);
        chk("R11 pending while active", rfsh_req, 1);
        pulse_grant();
        chk("R11 grant ignored", rfsh_req, 1);
        repeat (320) @(negedge clk);
        reg_wr(2'd0, ctl(0, 0, 3'd0, 1, 0));
        chk("R11 still one pending", rfsh_req, 1);
        chk("R11 still active", rfsh_active, 1);
        @(negedge clk); rfsh_done = 1'b1;
        @(negedge clk); rfsh_done = 1'b0;
        chk("R11 done ends cycle", rfsh_active, 0);
        pulse_grant();
        chk("R11 pending accepted", rfsh_req, 0);
        chk("R11 second cycle", rfsh_active, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule